// File: doc/BRIEF.md
# Flash Ready/Busy Status Pin Driver

This block produces the single ready/busy status pin of a flash-style memory controller. It watches the activity flags of the controller's write state machine: erase, program and lock-bit configuration busy, plus erase and program suspend. From these it drives the pin in one of two styles. In the default level style the pin stays low while an operation runs and high otherwise. In a pulse style the pin idles high and gives a short low pulse when a chosen kind of operation completes.

A small configuration port selects the style. A configuration write that arrives while an operation is running is held and applied once the machine is idle. An active-low power-down input forces the pin high. It also clears the status bits, drops any held or active configuration back to level style and cancels a pulse in progress. Two status bits record the ready condition and whether any operation has completed.

Top module: `rdy_pin_drv`

## Requirements
- R1: After the synchronous reset `rst`, `ready_pin` is 1, `stat_done` is 0 and the output style is level mode.
- R2: In level mode (`cfg_mode` code 2'b00) `ready_pin` is 0 in the cycle after any of the following is present: lock busy, erase busy without erase suspend, or program busy without program suspend.
- R3: In level mode `ready_pin` is 1 in the cycle after the machine is idle, after erase is busy and suspended with no program busy, and after program is busy and suspended.
- R4: While `pd_n` is 0, `ready_pin` is 1 and both status bits are 0 from the next cycle on. Power-down also returns the style to level mode and ends any pulse in progress.
- R5: With code 2'b10 (program completion) or 2'b01 (erase completion), a `done_stb` whose `done_kind` matches drives `ready_pin` low for exactly 2 cycles, starting the cycle after the strobe. `done_kind` is 2'b00 for program, 2'b01 for erase and 2'b10 for lock-bit.
- R6: In any pulse mode `ready_pin` stays 1 while operations are busy. A completion strobe of a kind the mode does not enable, including every lock-bit completion, causes no pulse.
- R7: Code 2'b11 pulses on both program and erase completion.
- R8: A `cfg_wr` made while an operation is busy (the R2 busy condition) does not change the style until a cycle in which no operation is busy. The held value is then applied.
- R9: `stat_ready` equals the level-mode ready condition of the previous cycle in every output style.
- R10: `stat_done` becomes 1 the cycle after any `done_stb` and stays 1 until reset or power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Active-low reset/power-down |
| erase_busy | input | 1 | Erase operation running |
| prog_busy | input | 1 | Program operation running |
| lock_busy | input | 1 | Lock-bit configuration running |
| erase_susp | input | 1 | Erase suspended |
| prog_susp | input | 1 | Program suspended |
| done_stb | input | 1 | One-cycle operation-complete strobe |
| done_kind | input | 2 | Type of the completed operation |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Requested output style |
| ready_pin | output | 1 | Status pin, registered |
| stat_ready | output | 1 | Status register ready bit |
| stat_done | output | 1 | Status register completion bit |

## Verification
The hardest situation to reach is a configuration write held back by a busy machine. Its effect is invisible while the operation runs, because in level mode the pin is low anyway. The bench therefore reverses the usual order. It first enters program-pulse mode and starts a program, so the pin is high. It then writes level mode. A correct design keeps the pin high until the program ends and pulls it low only when a new program starts. The opposite direction is covered as well: a pulse mode is written during a lock operation and is shown to take effect after the lock ends.

// File: rtl/rdy_pkg.sv
package rdy_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_ERASE = 2'b01,
    MODE_PROG  = 2'b10,
    MODE_BOTH  = 2'b11
  } out_mode_e;

  typedef enum logic [1:0] {
    KIND_PROG  = 2'b00,
    KIND_ERASE = 2'b01,
    KIND_LOCK  = 2'b10,
    KIND_RSVD  = 2'b11
  } done_kind_e;

  function automatic logic kind_enabled(out_mode_e m, done_kind_e k);
    logic hit;
    case (m)
      MODE_ERASE: hit = (k == KIND_ERASE);
      MODE_PROG:  hit = (k == KIND_PROG);
      MODE_BOTH:  hit = (k == KIND_ERASE) || (k == KIND_PROG);
      default:    hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/rdy_busy_eval.sv
module rdy_busy_eval (
  input  logic erase_busy,
  input  logic prog_busy,
  input  logic lock_busy,
  input  logic erase_susp,
  input  logic prog_susp,
  output logic busy_any
);
  logic erase_run;
  logic prog_run;

  always_comb begin
    erase_run = erase_busy && !erase_susp;
    prog_run  = prog_busy && !prog_susp;
    busy_any  = erase_run || prog_run || lock_busy;
  end
endmodule

// File: rtl/rdy_mode_reg.sv
module rdy_mode_reg
  import rdy_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pd_n,
  input  logic      busy_any,
  input  logic      cfg_wr,
  input  out_mode_e cfg_mode,
  output out_mode_e mode_q
);
  out_mode_e pend_mode_q;
  logic      pend_q;

  always_ff @(posedge clk) begin
    if (rst || !pd_n) begin
      mode_q      <= MODE_LEVEL;
      pend_mode_q <= MODE_LEVEL;
      pend_q      <= 1'b0;
    end else if (cfg_wr) begin
      if (!busy_any) begin
        mode_q <= cfg_mode;
        pend_q <= 1'b0;
      end else begin
        pend_mode_q <= cfg_mode;
        pend_q      <= 1'b1;
      end
    end else if (pend_q && !busy_any) begin
      mode_q <= pend_mode_q;
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rdy_pulse_gen.sv
module rdy_pulse_gen #(
  parameter int PULSE_LEN = 2,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  input  logic fire,
  output logic low_next
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (!pd_n)
      cnt_d = '0;
    else if (fire)
      cnt_d = LOAD;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = '0;
    low_next = (cnt_d != '0);
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rdy_pin_drv.sv
module rdy_pin_drv
  import rdy_pkg::*;
#(
  parameter int PULSE_LEN = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pd_n,
  input  logic       erase_busy,
  input  logic       prog_busy,
  input  logic       lock_busy,
  input  logic       erase_susp,
  input  logic       prog_susp,
  input  logic       done_stb,
  input  logic [1:0] done_kind,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_mode,
  output logic       ready_pin,
  output logic       stat_ready,
  output logic       stat_done
);
  logic      busy_any;
  out_mode_e mode_q;
  logic      fire;
  logic      low_next;

  rdy_busy_eval u_busy (
    .erase_busy (erase_busy),
    .prog_busy  (prog_busy),
    .lock_busy  (lock_busy),
    .erase_susp (erase_susp),
    .prog_susp  (prog_susp),
    .busy_any   (busy_any)
  );

  rdy_mode_reg u_mode (
    .clk      (clk),
    .rst      (rst),
    .pd_n     (pd_n),
    .busy_any (busy_any),
    .cfg_wr   (cfg_wr),
    .cfg_mode (out_mode_e'(cfg_mode)),
    .mode_q   (mode_q)
  );

  assign fire = done_stb && kind_enabled(mode_q, done_kind_e'(done_kind));

  rdy_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .pd_n     (pd_n),
    .fire     (fire),
    .low_next (low_next)
  );

  always_ff @(posedge clk) begin
    if (rst || !pd_n) begin
      ready_pin  <= 1'b1;
      stat_ready <= 1'b0;
      stat_done  <= 1'b0;
    end else begin
      if (mode_q == MODE_LEVEL)
        ready_pin <= !busy_any;
      else
        ready_pin <= !low_next;
      stat_ready <= !busy_any;
      if (done_stb)
        stat_done <= 1'b1;
    end
  end
endmodule

// File: rtl/rdy_pin_chk.sv
module rdy_pin_chk
  import rdy_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      pd_n,
  input logic      erase_busy,
  input logic      prog_busy,
  input logic      lock_busy,
  input logic      erase_susp,
  input logic      prog_susp,
  input logic      ready_pin,
  input logic      stat_ready,
  input logic      stat_done,
  input out_mode_e mode_q
);
  logic run_now;
  assign run_now = lock_busy || (erase_busy && !erase_susp) || (prog_busy && !prog_susp);

  AST_PWRDN_PIN_HIGH: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> (ready_pin && !stat_ready && !stat_done)); // R4

  AST_LEVEL_LOCK_LOW: assert property (@(posedge clk) disable iff (rst)
    (pd_n && mode_q == MODE_LEVEL && lock_busy) |=> !ready_pin); // R2

  AST_STAT_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (pd_n && !run_now) |=> stat_ready); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pd_n && stat_done) |=> stat_done); // R10

  AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (pd_n && run_now) |=> $stable(mode_q)); // R8
endmodule

bind rdy_pin_drv rdy_pin_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pd_n       (pd_n),
  .erase_busy (erase_busy),
  .prog_busy  (prog_busy),
  .lock_busy  (lock_busy),
  .erase_susp (erase_susp),
  .prog_susp  (prog_susp),
  .ready_pin  (ready_pin),
  .stat_ready (stat_ready),
  .stat_done  (stat_done),
  .mode_q     (mode_q)
);

// File: tb/rdy_pin_drv_tb.sv
module rdy_pin_drv_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pd_n = 1'b1;
  logic       erase_busy = 1'b0;
  logic       prog_busy = 1'b0;
  logic       lock_busy = 1'b0;
  logic       erase_susp = 1'b0;
  logic       prog_susp = 1'b0;
  logic       done_stb = 1'b0;
  logic [1:0] done_kind = 2'b00;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       ready_pin;
  logic       stat_ready;
  logic       stat_done;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdy_pin_drv u_dut (
    .clk(clk), .rst(rst), .pd_n(pd_n),
    .erase_busy(erase_busy), .prog_busy(prog_busy), .lock_busy(lock_busy),
    .erase_susp(erase_susp), .prog_susp(prog_susp),
    .done_stb(done_stb), .done_kind(done_kind),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .ready_pin(ready_pin), .stat_ready(stat_ready), .stat_done(stat_done)
  );

  task automatic check(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // advance one clock; inputs change and outputs are sampled at negedges
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_all();
    erase_busy = 0; prog_busy = 0; lock_busy = 0;
    erase_susp = 0; prog_susp = 0; done_stb = 0; cfg_wr = 0;
  endtask

  task automatic write_cfg(logic [1:0] m);
    cfg_mode = m; cfg_wr = 1; tick(); cfg_wr = 0;
  endtask

  task automatic strobe(logic [1:0] k);
    done_kind = k; done_stb = 1; tick(); done_stb = 0;
  endtask

  task automatic do_reset();
    idle_all(); pd_n = 1; rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 pin after reset", ready_pin, 1'b1);
    check("R1 done after reset", stat_done, 1'b0);
    lock_busy = 1; tick();
    check("R1 level mode after reset", ready_pin, 1'b0);
    idle_all(); tick();
  endtask

  task automatic t_level();
    do_reset(); tick();
    check("R3 idle high", ready_pin, 1'b1);
    erase_busy = 1; tick();
    check("R2 erase low", ready_pin, 1'b0);
    erase_susp = 1; tick();
    check("R3 erase suspended high", ready_pin, 1'b1);
    prog_busy = 1; tick();
    check("R2 program during erase suspend low", ready_pin, 1'b0);
    prog_susp = 1; tick();
    check("R3 program suspended high", ready_pin, 1'b1);
    idle_all(); lock_busy = 1; tick();
    check("R2 lock low", ready_pin, 1'b0);
    idle_all(); tick();
    check("R3 back to idle high", ready_pin, 1'b1);
  endtask

  task automatic t_pulse_prog();
    do_reset();
    write_cfg(2'b10);
    prog_busy = 1; tick();
    check("R6 busy in pulse mode high", ready_pin, 1'b1);
    check("R9 ready bit low in pulse mode", stat_ready, 1'b0);
    prog_busy = 0;
    strobe(2'b00);
    check("R5 pulse cycle 1", ready_pin, 1'b0);
    check("R10 done set", stat_done, 1'b1);
    check("R9 ready bit idle", stat_ready, 1'b1);
    tick();
    check("R5 pulse cycle 2", ready_pin, 1'b0);
    tick();
    check("R5 pulse ended", ready_pin, 1'b1);
    strobe(2'b01);
    check("R6 erase strobe ignored", ready_pin, 1'b1);
    tick();
    check("R6 erase strobe ignored later", ready_pin, 1'b1);
    strobe(2'b10);
    check("R6 lock strobe ignored", ready_pin, 1'b1);
    tick(); tick();
    check("R10 done sticky", stat_done, 1'b1);
  endtask

  task automatic t_pulse_erase_both();
    do_reset();
    write_cfg(2'b01);
    strobe(2'b00);
    check("R6 program strobe ignored in erase mode", ready_pin, 1'b1);
    strobe(2'b01);
    check("R5 erase pulse cycle 1", ready_pin, 1'b0);
    tick();
    check("R5 erase pulse cycle 2", ready_pin, 1'b0);
    tick();
    check("R5 erase pulse ended", ready_pin, 1'b1);
    write_cfg(2'b11);
    strobe(2'b00);
    check("R7 both mode program pulse", ready_pin, 1'b0);
    tick(); tick();
    check("R7 program pulse ended", ready_pin, 1'b1);
    strobe(2'b01);
    check("R7 both mode erase pulse", ready_pin, 1'b0);
    tick(); tick();
    check("R7 erase pulse ended", ready_pin, 1'b1);
    strobe(2'b10);
    check("R7 lock strobe ignored in both mode", ready_pin, 1'b1);
  endtask

  task automatic t_defer();
    do_reset();
    write_cfg(2'b10);
    prog_busy = 1; tick();
    write_cfg(2'b00);
    check("R8 level change held while busy", ready_pin, 1'b1);
    tick();
    check("R8 still held", ready_pin, 1'b1);
    prog_busy = 0; tick();
    check("R8 idle after release", ready_pin, 1'b1);
    prog_busy = 1; tick();
    check("R8 held level mode applied", ready_pin, 1'b0);
    idle_all(); tick();
    lock_busy = 1; tick();
    write_cfg(2'b01);
    check("R8 lock still low", ready_pin, 1'b0);
    lock_busy = 0; tick();
    check("R8 lock done high", ready_pin, 1'b1);
    erase_busy = 1; tick();
    check("R8 erase pulse mode applied", ready_pin, 1'b1);
    idle_all(); tick();
  endtask

  task automatic t_pwrdn();
    do_reset();
    write_cfg(2'b10);
    strobe(2'b00);
    check("R4 pulse began", ready_pin, 1'b0);
    pd_n = 0; tick();
    check("R4 pin high in power-down", ready_pin, 1'b1);
    check("R4 done cleared", stat_done, 1'b0);
    check("R4 ready bit cleared", stat_ready, 1'b0);
    pd_n = 1; tick();
    check("R4 pulse aborted", ready_pin, 1'b1);
    prog_busy = 1; tick();
    check("R4 mode back to level", ready_pin, 1'b0);
    idle_all(); tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    t_level();
    t_pulse_prog();
    t_pulse_erase_both();
    t_defer();
    t_pwrdn();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule